// File: doc/BRIEF.md
# Sixteen-Bit Address Arithmetic Unit

This unit performs the 16-bit arithmetic that a small 8-bit processor core needs for addresses and register pairs. It adds a register pair into HL. It adds a signed byte offset to the stack pointer, and it can also send that same sum to HL. It steps a register pair up or down by one, and it moves the stack pointer by two for push and pop. The register file, memory traffic and the byte-wide ALU sit outside the unit.

The caller presents the current HL and SP values, the operand pair, a raw offset byte, a 3-bit operation code and the current flag nibble. In the same cycle the unit returns a 16-bit result, a code that says which register receives it, and the new flag nibble. The unit holds no state, so operations can be issued back to back without stalls.

For the pair operations (HL addition, increment and decrement), the caller drives the chosen register pair (BC, DE, HL or SP) on the pair input.

Top module: `addr_step_alu`

## Requirements
- R1: Operation code 1 (pair add) outputs HL plus the pair input, modulo 65536, with destination code 1 (HL).
- R2: For pair add, flag bit 3 (zero) passes through unchanged and flag bit 2 (subtract) is cleared. Flag bit 1 (half) is the carry out of bit 11 and flag bit 0 (carry) is the carry out of bit 15.
- R3: Operation code 2 (stack offset) outputs SP plus the offset byte sign-extended to 16 bits, modulo 65536, with destination code 2 (SP).
- R4: For operation codes 2 and 3, zero and subtract are cleared. Half is the carry out of bit 3 and carry is the carry out of bit 7, both taken from the unsigned sum of SP's low byte and the raw offset byte.
- R5: Operation code 3 (offset into HL) produces exactly the sum and flags of code 2, with destination code 1 (HL).
- R6: Operation codes 4 (increment) and 5 (decrement) output the pair input plus one or minus one, wrapping at both ends, with destination code 3 (pair).
- R7: Increment and decrement return the flag nibble unchanged.
- R8: Operation code 6 (push) outputs SP minus two and code 7 (pop) outputs SP plus two, each wrapping and each with destination code 2 (SP). Flags are unchanged for both.
- R9: Operation code 0 (idle) outputs result 0 and destination code 0 (none), and leaves the flags unchanged.
- R10: All outputs follow the inputs combinationally, with no clock edge between an operation and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (0 idle, 1 pair add, 2 stack offset, 3 offset into HL, 4 increment, 5 decrement, 6 push, 7 pop) |
| hl_in | input | 16 | Current HL value |
| sp_in | input | 16 | Current stack pointer |
| pair_in | input | 16 | Selected register pair operand |
| offset_in | input | 8 | Raw signed offset byte |
| flags_in | input | 4 | Current flags: bit 3 zero, 2 subtract, 1 half, 0 carry |
| result_out | output | 16 | Computed 16-bit value |
| dest_out | output | 2 | Destination: 0 none, 1 HL, 2 SP, 3 pair |
| flags_out | output | 4 | Updated flags, same bit layout as flags_in |

## Verification
Every result is due in the same cycle its operation is presented, with zero registers on the path. The bench therefore drives a full input vector, waits a short settling delay that contains no clock edge dependency, and compares all three outputs before it changes any input. The offset operations are swept exhaustively over every SP low byte paired with every offset byte. Pair addition is swept over a grid that crosses the bit-11 and bit-15 carry boundaries. The stepping operations are checked at both wrap points, using every flag nibble.

// File: rtl/addr_alu_pkg.sv
package addr_alu_pkg;

    localparam int ADDR_W   = 16;
    localparam int OFFS_W   = 8;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_ADD_PAIR  = 3'd1,
        OP_SP_OFFSET = 3'd2,
        OP_HL_SPOFF  = 3'd3,
        OP_PAIR_INC  = 3'd4,
        OP_PAIR_DEC  = 3'd5,
        OP_PUSH_ADJ  = 3'd6,
        OP_POP_ADJ   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_HL   = 2'd1,
        DST_SP   = 2'd2,
        DST_PAIR = 2'd3
    } dst_e;

    typedef struct packed {
        logic zero;
        logic sub;
        logic half;
        logic carry;
    } flags_t;

endpackage

// File: rtl/aau_pair_adder.sv
module aau_pair_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] sum_out,
    output logic         mid_carry,
    output logic         top_carry
);
    localparam int MID = W - 4;

    logic [W:0] full;

    always_comb begin
        full      = {1'b0, a_in} + {1'b0, b_in};
        sum_out   = full[W-1:0];
        top_carry = full[W];
        mid_carry = full[MID] ^ a_in[MID] ^ b_in[MID];
    end

    always_comb begin
        if (a_in == '0)
            AST_ADD_IDENTITY: assert (sum_out == b_in && !mid_carry && !top_carry); // R2
    end
endmodule

// File: rtl/aau_offset_adder.sv
module aau_offset_adder #(
    parameter int W    = 16,
    parameter int OFFW = 8
) (
    input  logic [W-1:0]    base_in,
    input  logic [OFFW-1:0] off_in,
    output logic [W-1:0]    sum_out,
    output logic            low_half,
    output logic            low_carry
);
    localparam int HALF = OFFW / 2;

    logic [W-1:0] ext_off;

    always_comb begin
        ext_off   = {{(W-OFFW){off_in[OFFW-1]}}, off_in};
        sum_out   = base_in + ext_off;
        low_half  = sum_out[HALF] ^ base_in[HALF] ^ ext_off[HALF];
        low_carry = sum_out[OFFW] ^ base_in[OFFW] ^ ext_off[OFFW];
    end

    always_comb begin
        if (off_in == '0)
            AST_ZERO_OFFSET: assert (sum_out == base_in && !low_half && !low_carry); // R4
    end
endmodule

// File: rtl/aau_step_unit.sv
module aau_step_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] value_in,
    input  logic         down,
    input  logic         double_step,
    output logic [W-1:0] value_out
);
    logic [W-1:0] step;

    always_comb begin
        step      = double_step ? W'(2) : W'(1);
        value_out = down ? (value_in - step) : (value_in + step);
    end

    always_comb begin
        AST_STEP_DIFF: assert ((down ? (value_in - value_out) : (value_out - value_in)) != '0); // R6
    end
endmodule

// File: rtl/addr_step_alu.sv
module addr_step_alu
    import addr_alu_pkg::*;
#(
    parameter int DATA_W = ADDR_W,
    parameter int OFF_W  = OFFS_W
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] hl_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] pair_in,
    input  logic [OFF_W-1:0]  offset_in,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] result_out,
    output logic [1:0]        dest_out,
    output logic [3:0]        flags_out
);
    op_e    op;
    flags_t fin;
    flags_t fout;
    dst_e   dst;

    logic [DATA_W-1:0] add_sum;
    logic              add_mid;
    logic              add_top;
    logic [DATA_W-1:0] off_sum;
    logic              off_half;
    logic              off_carry;
    logic [DATA_W-1:0] step_src;
    logic [DATA_W-1:0] step_res;
    logic              step_down;
    logic              step_two;

    assign op  = op_e'(op_sel);
    assign fin = flags_t'(flags_in);

    aau_pair_adder #(.W(DATA_W)) u_pair_add (
        .a_in      (hl_in),
        .b_in      (pair_in),
        .sum_out   (add_sum),
        .mid_carry (add_mid),
        .top_carry (add_top)
    );

    aau_offset_adder #(.W(DATA_W), .OFFW(OFF_W)) u_off_add (
        .base_in   (sp_in),
        .off_in    (offset_in),
        .sum_out   (off_sum),
        .low_half  (off_half),
        .low_carry (off_carry)
    );

    always_comb begin
        step_two  = (op == OP_PUSH_ADJ) || (op == OP_POP_ADJ);
        step_down = (op == OP_PUSH_ADJ) || (op == OP_PAIR_DEC);
        step_src  = step_two ? sp_in : pair_in;
    end

    aau_step_unit #(.W(DATA_W)) u_step (
        .value_in    (step_src),
        .down        (step_down),
        .double_step (step_two),
        .value_out   (step_res)
    );

    always_comb begin
        result_out = '0;
        dst        = DST_NONE;
        fout       = fin;
        unique case (op)
            OP_IDLE: begin
                result_out = '0;
            end
            OP_ADD_PAIR: begin
                result_out = add_sum;
                dst        = DST_HL;
                fout.sub   = 1'b0;
                fout.half  = add_mid;
                fout.carry = add_top;
            end
            OP_SP_OFFSET, OP_HL_SPOFF: begin
                result_out = off_sum;
                dst        = (op == OP_SP_OFFSET) ? DST_SP : DST_HL;
                fout.zero  = 1'b0;
                fout.sub   = 1'b0;
                fout.half  = off_half;
                fout.carry = off_carry;
            end
            OP_PAIR_INC, OP_PAIR_DEC: begin
                result_out = step_res;
                dst        = DST_PAIR;
            end
            OP_PUSH_ADJ, OP_POP_ADJ: begin
                result_out = step_res;
                dst        = DST_SP;
            end
            default: begin
                result_out = '0;
            end
        endcase
        dest_out  = dst;
        flags_out = fout;
    end

    always_comb begin
        if (op == OP_PAIR_INC || op == OP_PAIR_DEC)
            AST_INCDEC_FLAGS: assert (flags_out == flags_in); // R7
        if (op == OP_SP_OFFSET || op == OP_HL_SPOFF)
            AST_OFFSET_ZN_CLEAR: assert (flags_out[3:2] == 2'b00); // R4
        if (op == OP_ADD_PAIR)
            AST_ADDPAIR_ZERO_KEPT: assert (flags_out[3] == flags_in[3] && !flags_out[2]); // R2
        if (op == OP_PUSH_ADJ)
            AST_PUSH_LOWERS: assert (DATA_W'(result_out + DATA_W'(2)) == sp_in); // R8
        if (op == OP_POP_ADJ)
            AST_POP_RAISES: assert (DATA_W'(result_out - DATA_W'(2)) == sp_in); // R8
        AST_IDLE_NO_DEST: assert ((dest_out == 2'd0) == (op_sel == 3'd0)); // R9
    end
endmodule

// File: tb/sim_addr_step_alu.sv
`timescale 1ns/1ps
module sim_addr_step_alu;

    logic        clk;
    logic [2:0]  op_sel;
    logic [15:0] hl_in;
    logic [15:0] sp_in;
    logic [15:0] pair_in;
    logic [7:0]  offset_in;
    logic [3:0]  flags_in;
    logic [15:0] result_out;
    logic [1:0]  dest_out;
    logic [3:0]  flags_out;

    int checks;
    int fails;
    bit done;

    addr_step_alu u0 (
        .op_sel     (op_sel),
        .hl_in      (hl_in),
        .sp_in      (sp_in),
        .pair_in    (pair_in),
        .offset_in  (offset_in),
        .flags_in   (flags_in),
        .result_out (result_out),
        .dest_out   (dest_out),
        .flags_out  (flags_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic compare(input string req, input logic [15:0] er,
                           input logic [1:0] ed, input logic [3:0] ef);
        checks++;
        if (result_out !== er || dest_out !== ed || flags_out !== ef) begin
            fails++;
            $display("FAIL %s op=%0d: got res=%h dst=%0d flg=%b, expected res=%h dst=%0d flg=%b",
                     req, op_sel, result_out, dest_out, flags_out, er, ed, ef);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [15:0] hl, input logic [15:0] sp,
                         input logic [15:0] pr, input logic [7:0] off, input logic [3:0] fl);
        op_sel = op; hl_in = hl; sp_in = sp; pair_in = pr; offset_in = off; flags_in = fl;
        #1;
    endtask

    task automatic run_add_pair(input logic [15:0] hl, input logic [15:0] pr, input logic [3:0] fl);
        int s;
        logic h;
        logic c;
        s = int'(hl) + int'(pr);
        h = ((int'(hl) & 'hFFF) + (int'(pr) & 'hFFF)) > 'hFFF;
        c = s > 'hFFFF;
        apply(3'd1, hl, 16'h1234, pr, 8'h00, fl);
        compare("R1/R2", 16'(s), 2'd1, {fl[3], 1'b0, h, c});
        #1;
    endtask

    task automatic run_offset(input logic [2:0] op, input logic [15:0] sp, input logic [7:0] off,
                              input logic [3:0] fl);
        int s;
        logic h;
        logic c;
        s = int'(sp) + int'($signed(off));
        h = ((int'(sp) & 'hF) + (int'(off) & 'hF)) > 'hF;
        c = ((int'(sp) & 'hFF) + int'(off)) > 'hFF;
        apply(op, 16'hA5A5, sp, 16'h5A5A, off, fl);
        compare(op == 3'd2 ? "R3/R4" : "R5/R4", 16'(s & 'hFFFF),
                op == 3'd2 ? 2'd2 : 2'd1, {2'b00, h, c});
        #1;
    endtask

    initial begin
        #1520000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        @(negedge clk);

        // R9: idle behaviour, with every flag nibble
        for (int f = 0; f < 16; f++) begin
            apply(3'd0, 16'hFFFF, 16'hFFFE, 16'h8001, 8'hFF, 4'(f));
            compare("R9", 16'h0000, 2'd0, 4'(f));
            #1;
        end

        // R1/R2 boundary cases
        run_add_pair(16'h0FFF, 16'h0001, 4'b0000);
        run_add_pair(16'hFFFF, 16'h0001, 4'b1111);
        run_add_pair(16'h8000, 16'h8000, 4'b1000);
        run_add_pair(16'h0800, 16'h0800, 4'b0110);
        run_add_pair(16'h0000, 16'h0000, 4'b0101);
        // R1/R2 grid sweep
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                run_add_pair(16'(i * 1031 + (i << 10)), 16'((j * 2053) ^ 'h0F00), 4'(i ^ j));
            end
        end

        // R3/R4/R5: exhaustive over SP low byte and offset byte
        for (int lo = 0; lo < 256; lo++) begin
            for (int off = 0; off < 256; off++) begin
                run_offset(3'd2, 16'(((lo * 37) << 8) | lo), 8'(off), 4'(off));
                run_offset(3'd3, 16'(((lo * 91 + 255) << 8) | lo), 8'(off), 4'(lo));
            end
        end

        // R6/R7: increment and decrement, wrap points and sweep
        for (int f = 0; f < 16; f++) begin
            apply(3'd4, 16'h1111, 16'h2222, 16'hFFFF, 8'h80, 4'(f));
            compare("R6/R7 inc wrap", 16'h0000, 2'd3, 4'(f));
            #1;
            apply(3'd5, 16'h1111, 16'h2222, 16'h0000, 8'h80, 4'(f));
            compare("R6/R7 dec wrap", 16'hFFFF, 2'd3, 4'(f));
            #1;
        end
        for (int v = 0; v < 512; v++) begin
            apply(3'd4, 16'h0, 16'h0, 16'(v * 131), 8'h7F, 4'(v));
            compare("R6 inc", 16'(v * 131 + 1), 2'd3, 4'(v));
            #1;
            apply(3'd5, 16'h0, 16'h0, 16'(v * 131), 8'h7F, 4'(v));
            compare("R6 dec", 16'(v * 131 - 1), 2'd3, 4'(v));
            #1;
        end

        // R8: push and pop, wrap points and sweep
        for (int v = 0; v < 520; v++) begin
            logic [15:0] s;
            s = (v < 4) ? ((v < 2) ? 16'(v) : 16'(65534 + v - 2)) : 16'(v * 127);
            apply(3'd6, 16'hBEEF, s, 16'hCAFE, 8'h01, 4'(v));
            compare("R8 push", 16'(int'(s) - 2), 2'd2, 4'(v));
            #1;
            apply(3'd7, 16'hBEEF, s, 16'hCAFE, 8'h01, 4'(v));
            compare("R8 pop", 16'(int'(s) + 2), 2'd2, 4'(v));
            #1;
        end

        // R10: a new operation is reflected with no clock edge in between
        @(posedge clk);
        #1;
        apply(3'd4, 16'h0, 16'h0, 16'h00FF, 8'h00, 4'b1010);
        compare("R10 first", 16'h0100, 2'd3, 4'b1010);
        apply(3'd7, 16'h0, 16'h4000, 16'h00FF, 8'h00, 4'b0101);
        compare("R10 second", 16'h4002, 2'd2, 4'b0101);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule